// File: doc/BRIEF.md
# Asynchronous SRAM Write Cycle Sequencer

This block runs write cycles to an external asynchronous static RAM, 512K words of 8 bits in its default configuration, from a synchronous clock domain. A client offers an address and a data byte on a valid/ready handshake. The block captures both and drives the address, data, active-low chip select and active-low write enable pins through three timed phases: address setup, the write pulse and write recovery. The handshake returns to ready only after recovery has finished.

The write is in effect only while both strobes are low. It begins when the second strobe falls and ends when the first strobe rises. A shape input selects which strobe forms the pulse. In write-enable shape, chip select falls at the start of setup and write enable forms the pulse. In chip-select shape, write enable falls at the start of setup and chip select forms the pulse. Every interval is a count of clock cycles taken from configuration inputs, and a count of zero acts as one.

Each phase length is derived from the timing counts. Setup lasts the address-setup count. The pulse is long enough to meet the pulse-width, chip-select-width and data-setup counts. Recovery covers both the write-recovery and data-hold counts.

Top module: `sram_wr_ctrl`

## Requirements
- R1: After reset and whenever idle, chip select and write enable are high (1), the data-drive enable is low and request ready is high.
- R2: A request is taken on a clock edge where valid and ready are both high. Ready is low from the next cycle for exactly setup + pulse + recovery cycles, then returns high.
- R3: With the shape input at 0 (write-enable shape), chip select alone is low during setup, both strobes are low during the pulse, and chip select alone is low during recovery.
- R4: With the shape input at 1 (chip-select shape), write enable alone is low during setup, both strobes are low during the pulse, and write enable alone is low during recovery.
- R5: Setup lasts S = tAS clock cycles, from the address change to the cycle in which both strobes are low.
- R6: The pulse lasts P = max(tWP, C, tDW − S) cycles, with negative terms taken as 0. C is tCW − S in write-enable shape and tCW in chip-select shape.
- R7: Recovery, with one strobe still low, lasts max(tWR, tDH) cycles. The block is then idle.
- R8: The data-drive enable is high throughout setup and pulse, and for exactly tDH cycles after the write ends. It is low otherwise.
- R9: Any timing count of zero is treated as one cycle.
- R10: The address and data outputs hold the captured values from setup start through the end of recovery, whatever the request inputs do meanwhile.
- R11: The two strobes never fall on the same clock edge and never rise on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cs_mode | input | 1 | Cycle shape: 0 write enable forms the pulse, 1 chip select forms the pulse |
| cfg_t_as | input | CNT_W | Address setup count |
| cfg_t_wp | input | CNT_W | Write pulse width count |
| cfg_t_cw | input | CNT_W | Chip-select width count (chip select fall to write end) |
| cfg_t_dw | input | CNT_W | Data setup count before write end |
| cfg_t_dh | input | CNT_W | Data hold count after write end |
| cfg_t_wr | input | CNT_W | Write recovery count before address change |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Request address |
| req_data | input | DATA_W | Request data |
| sram_addr | output | ADDR_W | Memory address bus |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_out | output | DATA_W | Write data to the data pads |
| sram_dq_oe | output | 1 | Data pad drive enable |

## Verification
The bench targets the cases where a different constraint sets the pulse length: pulse width, chip-select width in write-enable shape (where setup already counts toward it), and data setup longer than address setup. A design that ignored the setup offset, or applied it in the wrong shape, would produce a pulse that is one or more cycles too long or too short. Recovery is tested with the data hold longer than the write recovery. A block that timed recovery from write recovery alone would release the address while the data is still required. All-zero and all-maximum counts test the clamp to one cycle and counter wrap. Changing the request inputs immediately after acceptance would expose any path that leaks them to the pins while a write is in progress.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_PULSE = 2'd2,
        PH_RECOV = 2'd3
    } phase_e;

    typedef enum logic {
        SHAPE_WE = 1'b0,
        SHAPE_CS = 1'b1
    } shape_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe;
    } pins_t;
endpackage

// File: rtl/sram_wr_timing.sv
module sram_wr_timing
    import sram_wr_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  shape_e           shape,
    input  logic [CNT_W-1:0] t_as,
    input  logic [CNT_W-1:0] t_wp,
    input  logic [CNT_W-1:0] t_cw,
    input  logic [CNT_W-1:0] t_dw,
    input  logic [CNT_W-1:0] t_dh,
    input  logic [CNT_W-1:0] t_wr,
    output logic [CNT_W-1:0] len_setup,
    output logic [CNT_W-1:0] len_pulse,
    output logic [CNT_W-1:0] len_recov,
    output logic [CNT_W-1:0] len_hold
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] as_c, wp_c, cw_c, dw_c, dh_c, wr_c;
    logic [CNT_W-1:0] cw_rel, dw_rel, p_tmp;

    // zero counts behave as one cycle
    always_comb begin
        as_c = (t_as == ZERO) ? ONE : t_as;
        wp_c = (t_wp == ZERO) ? ONE : t_wp;
        cw_c = (t_cw == ZERO) ? ONE : t_cw;
        dw_c = (t_dw == ZERO) ? ONE : t_dw;
        dh_c = (t_dh == ZERO) ? ONE : t_dh;
        wr_c = (t_wr == ZERO) ? ONE : t_wr;
    end

    always_comb begin
        // chip select width: in write-enable shape chip select already fell at setup start
        if (shape == SHAPE_CS) begin
            cw_rel = cw_c;
        end else begin
            cw_rel = (cw_c > as_c) ? (cw_c - as_c) : ZERO;
        end
        // data is driven from setup start, so setup cycles count toward data setup
        dw_rel    = (dw_c > as_c) ? (dw_c - as_c) : ZERO;
        p_tmp     = (wp_c > cw_rel) ? wp_c : cw_rel;
        len_pulse = (p_tmp > dw_rel) ? p_tmp : dw_rel;
        len_setup = as_c;
        len_recov = (wr_c > dh_c) ? wr_c : dh_c;
        len_hold  = dh_c;
    end
endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
    import sram_wr_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  phase_e           phase,
    input  shape_e           shape,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] hold,
    output pins_t            pins
);
    always_comb begin
        pins = '{cs_n: 1'b1, we_n: 1'b1, oe: 1'b0};
        unique case (phase)
            PH_IDLE: begin
                pins = '{cs_n: 1'b1, we_n: 1'b1, oe: 1'b0};
            end
            PH_SETUP, PH_RECOV: begin
                // the leading strobe is low, the pulse strobe is high
                pins.cs_n = (shape == SHAPE_CS);
                pins.we_n = (shape == SHAPE_WE);
                pins.oe   = (phase == PH_SETUP) ? 1'b1 : (cnt < hold);
            end
            PH_PULSE: begin
                pins = '{cs_n: 1'b0, we_n: 1'b0, oe: 1'b1};
            end
            default: begin
                pins = '{cs_n: 1'b1, we_n: 1'b1, oe: 1'b0};
            end
        endcase
    end
endmodule

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  shape_e            shape_in,
    input  logic [CNT_W-1:0]  len_setup,
    input  logic [CNT_W-1:0]  len_pulse,
    input  logic [CNT_W-1:0]  len_recov,
    input  logic [CNT_W-1:0]  len_hold,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    output phase_e            phase_nxt,
    output shape_e            shape_nxt,
    output logic [CNT_W-1:0]  cnt_nxt,
    output logic [CNT_W-1:0]  hold_nxt,
    input  pins_t             pins_nxt,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] data_out,
    output pins_t             pins_out
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        phase_e            ph;
        shape_e            shape;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  l_setup;
        logic [CNT_W-1:0]  l_pulse;
        logic [CNT_W-1:0]  l_recov;
        logic [CNT_W-1:0]  l_hold;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } core_t;

    core_t core_d, core_q;
    pins_t pins_q;

    always_comb begin
        core_d = core_q;
        unique case (core_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    core_d.ph      = PH_SETUP;
                    core_d.cnt     = '0;
                    core_d.shape   = shape_in;
                    core_d.l_setup = len_setup;
                    core_d.l_pulse = len_pulse;
                    core_d.l_recov = len_recov;
                    core_d.l_hold  = len_hold;
                    core_d.addr    = req_addr;
                    core_d.data    = req_data;
                end
            end
            PH_SETUP: begin
                if (core_q.cnt == core_q.l_setup - ONE) begin
                    core_d.ph  = PH_PULSE;
                    core_d.cnt = '0;
                end else begin
                    core_d.cnt = core_q.cnt + ONE;
                end
            end
            PH_PULSE: begin
                if (core_q.cnt == core_q.l_pulse - ONE) begin
                    core_d.ph  = PH_RECOV;
                    core_d.cnt = '0;
                end else begin
                    core_d.cnt = core_q.cnt + ONE;
                end
            end
            PH_RECOV: begin
                if (core_q.cnt == core_q.l_recov - ONE) begin
                    core_d.ph  = PH_IDLE;
                    core_d.cnt = '0;
                end else begin
                    core_d.cnt = core_q.cnt + ONE;
                end
            end
            default: begin
                core_d.ph  = PH_IDLE;
                core_d.cnt = '0;
            end
        endcase
    end

    // next state goes to the pin decoder so that the strobes leave flops
    assign phase_nxt = core_d.ph;
    assign shape_nxt = core_d.shape;
    assign cnt_nxt   = core_d.cnt;
    assign hold_nxt  = core_d.l_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '{ph: PH_IDLE, shape: SHAPE_WE, cnt: '0,
                        l_setup: ONE, l_pulse: ONE, l_recov: ONE, l_hold: ONE,
                        addr: '0, data: '0};
            pins_q <= '{cs_n: 1'b1, we_n: 1'b1, oe: 1'b0};
        end else begin
            core_q <= core_d;
            pins_q <= pins_nxt;
        end
    end

    assign req_ready = (core_q.ph == PH_IDLE);
    assign addr_out  = core_q.addr;
    assign data_out  = core_q.data;
    assign pins_out  = pins_q;
endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cs_mode,
    input  logic [CNT_W-1:0]  cfg_t_as,
    input  logic [CNT_W-1:0]  cfg_t_wp,
    input  logic [CNT_W-1:0]  cfg_t_cw,
    input  logic [CNT_W-1:0]  cfg_t_dw,
    input  logic [CNT_W-1:0]  cfg_t_dh,
    input  logic [CNT_W-1:0]  cfg_t_wr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe
);
    shape_e           shape_cfg, shape_nxt;
    phase_e           phase_nxt;
    logic [CNT_W-1:0] len_setup, len_pulse, len_recov, len_hold;
    logic [CNT_W-1:0] cnt_nxt, hold_nxt;
    pins_t            pins_nxt, pins_out;

    assign shape_cfg = shape_e'(cfg_cs_mode);

    sram_wr_timing #(.CNT_W(CNT_W)) i_timing (
        .shape     (shape_cfg),
        .t_as      (cfg_t_as),
        .t_wp      (cfg_t_wp),
        .t_cw      (cfg_t_cw),
        .t_dw      (cfg_t_dw),
        .t_dh      (cfg_t_dh),
        .t_wr      (cfg_t_wr),
        .len_setup (len_setup),
        .len_pulse (len_pulse),
        .len_recov (len_recov),
        .len_hold  (len_hold)
    );

    sram_wr_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .shape_in  (shape_cfg),
        .len_setup (len_setup),
        .len_pulse (len_pulse),
        .len_recov (len_recov),
        .len_hold  (len_hold),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .req_ready (req_ready),
        .phase_nxt (phase_nxt),
        .shape_nxt (shape_nxt),
        .cnt_nxt   (cnt_nxt),
        .hold_nxt  (hold_nxt),
        .pins_nxt  (pins_nxt),
        .addr_out  (sram_addr),
        .data_out  (sram_dq_out),
        .pins_out  (pins_out)
    );

    sram_wr_pins #(.CNT_W(CNT_W)) i_pins (
        .phase (phase_nxt),
        .shape (shape_nxt),
        .cnt   (cnt_nxt),
        .hold  (hold_nxt),
        .pins  (pins_nxt)
    );

    assign sram_cs_n  = pins_out.cs_n;
    assign sram_we_n  = pins_out.we_n;
    assign sram_dq_oe = pins_out.oe;
endmodule

// File: rtl/sram_wr_chk.sv
module sram_wr_chk #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_cs_mode,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_cs_n,
    input logic              sram_we_n,
    input logic [DATA_W-1:0] sram_dq_out,
    input logic              sram_dq_oe
);
    a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_cs_n && sram_we_n && !sram_dq_oe));

    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r3_we_pulse_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sram_we_n) && !cfg_cs_mode) |-> !sram_cs_n);

    a_r4_cs_pulse_after_we: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sram_cs_n) && cfg_cs_mode) |-> !sram_we_n);

    a_r8_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && !sram_we_n) |-> sram_dq_oe);

    a_r8_release_outside_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_dq_oe) |-> (sram_cs_n || sram_we_n));

    a_r10_bus_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((!sram_cs_n || !sram_we_n) && $past(!sram_cs_n || !sram_we_n))
        |-> ($stable(sram_addr) && $stable(sram_dq_out)));

    a_r11_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !($fell(sram_cs_n) && $fell(sram_we_n)));

    a_r11_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(sram_cs_n) && $rose(sram_we_n)));
endmodule

bind sram_wr_ctrl sram_wr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_cs_mode (cfg_cs_mode),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .sram_addr   (sram_addr),
    .sram_cs_n   (sram_cs_n),
    .sram_we_n   (sram_we_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe)
);

// File: tb/test_sram_wr_ctrl.sv
`timescale 1ns/1ps
module test_sram_wr_ctrl;
    localparam int ADDR_W = 19;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_cs_mode = 1'b0;
    logic [CNT_W-1:0]  cfg_t_as = '0, cfg_t_wp = '0, cfg_t_cw = '0;
    logic [CNT_W-1:0]  cfg_t_dw = '0, cfg_t_dh = '0, cfg_t_wr = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic [ADDR_W-1:0] sram_addr;
    logic              sram_cs_n, sram_we_n, sram_dq_oe;
    logic [DATA_W-1:0] sram_dq_out;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    sram_wr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_sram_wr_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_cs_mode(cfg_cs_mode),
        .cfg_t_as(cfg_t_as), .cfg_t_wp(cfg_t_wp), .cfg_t_cw(cfg_t_cw),
        .cfg_t_dw(cfg_t_dw), .cfg_t_dh(cfg_t_dh), .cfg_t_wr(cfg_t_wr),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data),
        .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int clamp1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_checks++;
                n_fails++;
                $display("FAIL R2 watchdog: actual %0d cycles expected below %0d", cycles, 100000);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
                $finish;
            end
        end
    end

    // one full write, measured at the pins, compared with R2-R10 arithmetic
    task automatic run_write(input string name, input bit cs_shape,
                             input int as_i, input int wp_i, input int cw_i,
                             input int dw_i, input int dh_i, input int wr_i,
                             input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        int s_e, p_e, r_e, h_e, cw_rel, dw_rel;
        int s_n, p_n, r_n, h_n, busy, ph;
        bit shape_ok, hold_ok, drive_ok;
        s_e    = clamp1(as_i);
        cw_rel = cs_shape ? clamp1(cw_i) : max2(clamp1(cw_i) - s_e, 0);
        dw_rel = max2(clamp1(dw_i) - s_e, 0);
        p_e    = max2(max2(clamp1(wp_i), cw_rel), dw_rel);
        h_e    = clamp1(dh_i);
        r_e    = max2(clamp1(wr_i), h_e);

        @(negedge clk);
        cfg_cs_mode = cs_shape;
        cfg_t_as = CNT_W'(as_i); cfg_t_wp = CNT_W'(wp_i); cfg_t_cw = CNT_W'(cw_i);
        cfg_t_dw = CNT_W'(dw_i); cfg_t_dh = CNT_W'(dh_i); cfg_t_wr = CNT_W'(wr_i);
        req_addr = a; req_data = d; req_valid = 1'b1;
        @(negedge clk);
        // request taken at the edge just passed; scramble inputs (R10)
        req_valid = 1'b0;
        req_addr  = ~a;
        req_data  = ~d;
        s_n = 0; p_n = 0; r_n = 0; h_n = 0; busy = 0; ph = 0;
        shape_ok = 1'b1; hold_ok = 1'b1; drive_ok = 1'b1;
        while (!req_ready && busy < 100) begin
            busy++;
            if (sram_addr != a || sram_dq_out != d) hold_ok = 1'b0;
            if (!sram_cs_n && !sram_we_n) begin
                if (ph == 2) shape_ok = 1'b0;
                ph = 1;
                p_n++;
                if (!sram_dq_oe) drive_ok = 1'b0;
            end else begin
                if (ph == 1) ph = 2;
                if (sram_cs_n != cs_shape || sram_we_n != !cs_shape) shape_ok = 1'b0;
                if (ph == 0) begin
                    s_n++;
                    if (!sram_dq_oe) drive_ok = 1'b0;
                end else begin
                    r_n++;
                    if (sram_dq_oe) h_n++;
                end
            end
            @(negedge clk);
        end
        $display("scenario %s", name);
        check(busy == s_e + p_e + r_e, "R2 busy cycles", busy, s_e + p_e + r_e);
        if (cs_shape) check(shape_ok, "R4 chip-select shape", shape_ok, 1);
        else          check(shape_ok, "R3 write-enable shape", shape_ok, 1);
        check(s_n == s_e, "R5 setup cycles", s_n, s_e);
        check(p_n == p_e, "R6 pulse cycles", p_n, p_e);
        check(r_n == r_e, "R7 recovery cycles", r_n, r_e);
        check(drive_ok && h_n == h_e, "R8 drive enable hold cycles", h_n, h_e);
        check(hold_ok, "R10 address and data held", hold_ok, 1);
        check(sram_cs_n && sram_we_n && !sram_dq_oe && req_ready, "R1 idle after write",
              {sram_cs_n, sram_we_n, sram_dq_oe, req_ready}, 4'b1101);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(sram_cs_n && sram_we_n && !sram_dq_oe && req_ready, "R1 reset state",
              {sram_cs_n, sram_we_n, sram_dq_oe, req_ready}, 4'b1101);
    endtask

    task automatic test_zero_counts();
        // R9: every count zero behaves as one cycle
        run_write("R9 zero counts", 1'b0, 0, 0, 0, 0, 0, 0, 19'h00001, 8'h5A);
    endtask

    task automatic test_back_to_back();
        run_write("back to back first", 1'b1, 2, 2, 1, 1, 1, 1, 19'h2AAAA, 8'h33);
        run_write("back to back second", 1'b0, 1, 1, 1, 1, 1, 3, 19'h15555, 8'hCC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_write("WE shape, pulse width rules", 1'b0, 2, 3, 1, 1, 1, 2, 19'h12345, 8'hA5);
        run_write("CS shape, chip select width rules", 1'b1, 1, 2, 4, 1, 2, 1, 19'h7FFFF, 8'h3C);
        run_write("WE shape, chip select width minus setup", 1'b0, 2, 1, 6, 1, 1, 1, 19'h00F0F, 8'h81);
        run_write("CS shape, data setup rules", 1'b1, 1, 1, 1, 5, 3, 1, 19'h40000, 8'hFF);
        test_zero_counts();
        run_write("WE shape, hold longer than recovery", 1'b0, 3, 2, 2, 2, 5, 2, 19'h0BEEF, 8'h00);
        run_write("WE shape, all maximum", 1'b0, 15, 15, 15, 15, 15, 15, 19'h55555, 8'h96);
        run_write("CS shape, all maximum", 1'b1, 15, 15, 15, 15, 15, 15, 19'h2F0F0, 8'h69);
        test_back_to_back();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule